// File: doc/BRIEF.md
# Three-Level Matrix Converter Gate Sequencer

This block drives the twelve bidirectional switches of a converter in which each of three load terminals (a, b, c) can be tied to one of four source nodes: the three supply phases A, B, C and the star point N of the input filter. The block models the converter as a rectifier stage followed by a two-level inverter stage. The rectifier stage chooses which source nodes feed an internal positive and negative rail. The inverter stage ties each load terminal to one of those rails. The gate pattern is the combination of the two choices.

A free-running timer divides time into switching periods of `CLK_HZ/SW_HZ` clock cycles, 6 kHz by default. During the last cycle of each period the block captures one frame from an upstream modulator. A frame holds three rectifier vector selectors with their durations in cycles, an inverter sector, and two renormalised inverter shares. The block checks the frame. If the frame is legal, the next period steps through the pieces of that frame. If it is not, an error flag is raised and the last legal frame is replayed.

Each virtual vector is played as two equal halves built from neighbouring phase-to-neutral vectors, so that the neutral current averages to zero over the period. The inverter only alternates between two adjacent active states and never applies a zero state.

Top module: `tmc_pwm_seq`

## Requirements
- R1: `sw_en_o` bit `4*p + s` closes the switch from source s (0=A, 1=B, 2=C, 3=N) to load terminal p (0=a, 1=b, 2=c). Whenever `idle_o` is low, each 4-bit group has exactly one bit set.
- R2: After reset, `sw_en_o` is zero and `idle_o` is high, and both stay so until the first legal frame has been captured. Once `idle_o` falls it never rises again.
- R3: `load_o` is high in exactly one cycle out of every `CLK_HZ/SW_HZ` cycles: the last cycle of each period. The first such cycle is the `CLK_HZ/SW_HZ`-th cycle after reset. Inputs are captured at the clock edge that ends that cycle, and the captured frame governs the whole next period, starting with its first cycle.
- R4: A frame is legal only when all of these hold: the three durations sum to the period length; each selector is a legal code; every virtual selector has an even duration; the inverter sector is 1 to 6; and the two shares sum to `2**FRAC_W`. An illegal frame sets `err_o` high for the following period and the previous legal frame is replayed. If there is none, the block stays idle. `err_o` and `idle_o` change only right after a `load_o` cycle.
- R5: The selectors are played in order 0, 1, 2, each for its duration; a zero duration is skipped. Each rectifier piece is split into an alpha part of `floor(len*da/2**FRAC_W)` cycles followed by a beta part that takes the rest of the piece.
- R6: Selector code `{2'b01, k}` with k in 1..6 is a line vector with (positive rail, negative rail) set to AB, AC, BC, BA, CA, CB for k = 1..6.
- R7: Selector code `{2'b10, k}` is virtual vector k. It plays phase vector k-1 (k=1 wraps to 6) for half the duration and then phase vector k for the other half. Phase vectors 1..6 put (A,N), (N,C), (B,N), (N,A), (C,N), (N,B) on the (positive, negative) rails.
- R8: Selector code `{2'b00, s}` with s in 0..3 is a zero vector: both rails are tied to source s, so all three load terminals close on that source.
- R9: Inverter state codes use bit 2 for terminal a, bit 1 for b and bit 0 for c; a 1 means the positive rail. States 1..6 are 100, 110, 010, 011, 001, 101. For sector n, the alpha part uses state n and the beta part uses state n+1 (6 wraps to 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rvec_sel | input | 3x5 | Rectifier selectors, each {kind[1:0], index[2:0]} |
| rvec_dur | input | 3xCNT_W | Duration of each selector in clock cycles |
| inv_sector | input | 3 | Inverter sector, 1 to 6 |
| inv_da | input | FRAC_W+1 | Alpha share, scaled by 2**FRAC_W |
| inv_db | input | FRAC_W+1 | Beta share, scaled by 2**FRAC_W |
| load_o | output | 1 | High in the last cycle of a period; the frame is captured at its end |
| sw_en_o | output | 12 | Switch enables, bit 4*terminal + source |
| idle_o | output | 1 | High until a first legal frame has been captured |
| err_o | output | 1 | The frame captured at the last boundary was illegal |

## Verification
The assertions assume no legality of the frame inputs. Illegal selectors, odd virtual durations, bad sectors and wrong share sums are filtered inside the block, so the one-input-per-terminal property must hold whatever the upstream modulator presents. They do assume that the frame inputs are steady across the capturing edge. The stimulus therefore changes the frame only on falling edges, mixes legal frames with each kind of illegal one, and includes sector and index wrap-arounds, shares of zero and full scale, and zero-length pieces.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    localparam int NUM_SLOT  = 3;
    localparam int NUM_PIECE = 2 * NUM_SLOT;
    localparam int NUM_SEG   = 2 * NUM_PIECE;
    localparam int NUM_TERM  = 3;
    localparam int NUM_SRC   = 4;
    localparam int SW_W      = NUM_TERM * NUM_SRC;

    typedef enum logic [1:0] {
        RK_ZERO = 2'd0,
        RK_LINE = 2'd1,
        RK_VIRT = 2'd2,
        RK_RSVD = 2'd3
    } rkind_e;

    localparam logic [1:0] SRC_A = 2'd0;
    localparam logic [1:0] SRC_B = 2'd1;
    localparam logic [1:0] SRC_C = 2'd2;
    localparam logic [1:0] SRC_N = 2'd3;

    typedef struct packed {
        logic [1:0] pos;
        logic [1:0] neg;
    } rails_t;

    function automatic rails_t line_rails(input logic [2:0] k);
        rails_t r;
        case (k)
            3'd1:    r = '{pos: SRC_A, neg: SRC_B};
            3'd2:    r = '{pos: SRC_A, neg: SRC_C};
            3'd3:    r = '{pos: SRC_B, neg: SRC_C};
            3'd4:    r = '{pos: SRC_B, neg: SRC_A};
            3'd5:    r = '{pos: SRC_C, neg: SRC_A};
            3'd6:    r = '{pos: SRC_C, neg: SRC_B};
            default: r = '{pos: SRC_A, neg: SRC_A};
        endcase
        return r;
    endfunction

    function automatic rails_t phase_rails(input logic [2:0] k);
        rails_t r;
        case (k)
            3'd1:    r = '{pos: SRC_A, neg: SRC_N};
            3'd2:    r = '{pos: SRC_N, neg: SRC_C};
            3'd3:    r = '{pos: SRC_B, neg: SRC_N};
            3'd4:    r = '{pos: SRC_N, neg: SRC_A};
            3'd5:    r = '{pos: SRC_C, neg: SRC_N};
            3'd6:    r = '{pos: SRC_N, neg: SRC_B};
            default: r = '{pos: SRC_N, neg: SRC_N};
        endcase
        return r;
    endfunction

    function automatic logic [2:0] ring_prev(input logic [2:0] k);
        return (k == 3'd1) ? 3'd6 : k - 3'd1;
    endfunction

    function automatic logic [2:0] ring_next(input logic [2:0] k);
        return (k == 3'd6) ? 3'd1 : k + 3'd1;
    endfunction

    function automatic logic ring_ok(input logic [2:0] k);
        return (k != 3'd0) && (k != 3'd7);
    endfunction

    // bit 2 = terminal a, bit 0 = terminal c; 1 = positive rail
    function automatic logic [2:0] inv_state(input logic [2:0] k);
        logic [2:0] v;
        case (k)
            3'd1:    v = 3'b100;
            3'd2:    v = 3'b110;
            3'd3:    v = 3'b010;
            3'd4:    v = 3'b011;
            3'd5:    v = 3'b001;
            3'd6:    v = 3'b101;
            default: v = 3'b000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tmc_slot_expand.sv
module tmc_slot_expand
    import tmc_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic [4:0]       sel,
    input  logic [CNT_W-1:0] dur,
    output rails_t           r_first,
    output rails_t           r_second,
    output logic [CNT_W-1:0] len_first,
    output logic [CNT_W-1:0] len_second,
    output logic             legal
);

    rkind_e     kind;
    logic [2:0] idx;

    always_comb begin
        kind       = rkind_e'(sel[4:3]);
        idx        = sel[2:0];
        r_first    = '{pos: idx[1:0], neg: idx[1:0]};
        r_second   = r_first;
        len_first  = dur;
        len_second = '0;
        legal      = 1'b0;
        case (kind)
            RK_ZERO: begin
                legal = !idx[2];
            end
            RK_LINE: begin
                legal    = ring_ok(idx);
                r_first  = line_rails(idx);
                r_second = r_first;
            end
            RK_VIRT: begin
                legal      = ring_ok(idx) && !dur[0];
                r_first    = phase_rails(ring_prev(idx));
                r_second   = phase_rails(idx);
                len_first  = dur >> 1;
                len_second = dur >> 1;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tmc_seg_plan.sv
module tmc_seg_plan
    import tmc_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int FRAC_W = 8
) (
    input  logic [NUM_PIECE-1:0][CNT_W-1:0] piece_len,
    input  logic [FRAC_W:0]                 share_a,
    output logic [NUM_SEG-1:0][CNT_W-1:0]   seg_end
);

    localparam int PROD_W = CNT_W + FRAC_W + 1;

    logic [NUM_PIECE-1:0][CNT_W-1:0]  len_a;
    logic [NUM_PIECE-1:0][CNT_W-1:0]  len_b;
    logic [NUM_PIECE-1:0][PROD_W-1:0] prod;

    for (genvar g = 0; g < NUM_PIECE; g++) begin : g_piece
        assign prod[g]  = {{(FRAC_W+1){1'b0}}, piece_len[g]} * {{CNT_W{1'b0}}, share_a};
        assign len_a[g] = prod[g][FRAC_W +: CNT_W];
        assign len_b[g] = piece_len[g] - len_a[g];
    end

    always_comb begin
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int p = 0; p < NUM_PIECE; p++) begin
            acc              = acc + len_a[p];
            seg_end[2*p]     = acc;
            acc              = acc + len_b[p];
            seg_end[2*p + 1] = acc;
        end
    end

endmodule

// File: rtl/tmc_gate_map.sv
module tmc_gate_map
    import tmc_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic [NUM_SEG-1:0][CNT_W-1:0] seg_end,
    input  rails_t [NUM_PIECE-1:0]        rails,
    input  logic [2:0]                    vec_a,
    input  logic [2:0]                    vec_b,
    input  logic [CNT_W-1:0]              pos,
    output logic [SW_W-1:0]               sw
);

    logic [3:0] hit;
    logic [2:0] piece;
    rails_t     cur;
    logic [2:0] vec;

    always_comb begin
        hit = 4'(NUM_SEG - 1);
        for (int j = NUM_SEG - 1; j >= 0; j--) begin
            if (pos < seg_end[j]) begin
                hit = 4'(j);
            end
        end
        piece = hit[3:1];
        cur   = rails[piece];
        vec   = hit[0] ? vec_b : vec_a;
    end

    for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
        logic [1:0] tie;
        assign tie = vec[NUM_TERM-1-t] ? cur.pos : cur.neg;
        assign sw[t*NUM_SRC +: NUM_SRC] = 4'b0001 << tie;
    end

endmodule

// File: rtl/tmc_pwm_seq.sv
module tmc_pwm_seq
    import tmc_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000,
    parameter int SW_HZ  = 6_000,
    parameter int FRAC_W = 8,
    localparam int PERIOD_CYC = CLK_HZ / SW_HZ,
    localparam int CNT_W      = $clog2(PERIOD_CYC + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SLOT-1:0][4:0]        rvec_sel,
    input  logic [NUM_SLOT-1:0][CNT_W-1:0]  rvec_dur,
    input  logic [2:0]                      inv_sector,
    input  logic [FRAC_W:0]                 inv_da,
    input  logic [FRAC_W:0]                 inv_db,
    output logic                            load_o,
    output logic [SW_W-1:0]                 sw_en_o,
    output logic                            idle_o,
    output logic                            err_o
);

    localparam int SUM_W = CNT_W + 2;
    localparam logic [CNT_W-1:0]  LAST_POS   = CNT_W'(PERIOD_CYC - 1);
    localparam logic [SUM_W-1:0]  PERIOD_SUM = SUM_W'(PERIOD_CYC);
    localparam logic [FRAC_W+1:0] SHARE_FULL = (FRAC_W+2)'(1) << FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0]               cnt;
        logic                           loaded;
        logic                           err;
        logic [NUM_SEG-1:0][CNT_W-1:0]  ends;
        rails_t [NUM_PIECE-1:0]         rails;
        logic [2:0]                     vec_a;
        logic [2:0]                     vec_b;
    } st_t;

    st_t             st_d, st_q;
    logic [SW_W-1:0] sw_d, sw_q;

    // frame decode
    rails_t [NUM_PIECE-1:0]              in_rails;
    logic   [NUM_PIECE-1:0][CNT_W-1:0]   in_len;
    logic   [NUM_SLOT-1:0]               slot_ok;
    logic   [NUM_SEG-1:0][CNT_W-1:0]     in_ends;
    logic   [SUM_W-1:0]                  dur_sum;
    logic   [FRAC_W+1:0]                 share_sum;
    logic                                sec_ok;
    logic                                frame_ok;
    logic   [SW_W-1:0]                   gate_sw;

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        tmc_slot_expand #(.CNT_W(CNT_W)) u_slot (
            .sel        (rvec_sel[s]),
            .dur        (rvec_dur[s]),
            .r_first    (in_rails[2*s]),
            .r_second   (in_rails[2*s + 1]),
            .len_first  (in_len[2*s]),
            .len_second (in_len[2*s + 1]),
            .legal      (slot_ok[s])
        );
    end

    tmc_seg_plan #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_plan (
        .piece_len (in_len),
        .share_a   (inv_da),
        .seg_end   (in_ends)
    );

    always_comb begin
        dur_sum = '0;
        for (int s = 0; s < NUM_SLOT; s++) begin
            dur_sum = dur_sum + SUM_W'(rvec_dur[s]);
        end
        share_sum = {1'b0, inv_da} + {1'b0, inv_db};
        sec_ok    = ring_ok(inv_sector);
        frame_ok  = (&slot_ok) && (dur_sum == PERIOD_SUM)
                    && (share_sum == SHARE_FULL) && sec_ok;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST_POS) begin
            st_d.cnt = '0;
            if (frame_ok) begin
                st_d.loaded = 1'b1;
                st_d.err    = 1'b0;
                st_d.ends   = in_ends;
                st_d.rails  = in_rails;
                st_d.vec_a  = inv_state(inv_sector);
                st_d.vec_b  = inv_state(ring_next(inv_sector));
            end else begin
                st_d.err    = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    tmc_gate_map #(.CNT_W(CNT_W)) u_gate (
        .seg_end (st_d.ends),
        .rails   (st_d.rails),
        .vec_a   (st_d.vec_a),
        .vec_b   (st_d.vec_b),
        .pos     (st_d.cnt),
        .sw      (gate_sw)
    );

    assign sw_d = st_d.loaded ? gate_sw : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            sw_q <= '0;
        end else begin
            st_q <= st_d;
            sw_q <= sw_d;
        end
    end

    assign load_o  = (st_q.cnt == LAST_POS);
    assign sw_en_o = sw_q;
    assign idle_o  = !st_q.loaded;
    assign err_o   = st_q.err;

endmodule

// File: rtl/tmc_pwm_seq_chk.sv
module tmc_pwm_seq_chk #(
    parameter int CLK_HZ = 125_000_000,
    parameter int SW_HZ  = 6_000,
    localparam int PERIOD_CYC = CLK_HZ / SW_HZ,
    localparam int CNT_W      = $clog2(PERIOD_CYC + 1)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        load_o,
    input logic [11:0] sw_en_o,
    input logic        idle_o,
    input logic        err_o
);

    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      gap_q <= '0;
        else if (load_o) gap_q <= '0;
        else             gap_q <= gap_q + 1'b1;
    end

    p_one_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |-> ($countones(sw_en_o[3:0]) == 1 && $countones(sw_en_o[7:4]) == 1
                     && $countones(sw_en_o[11:8]) == 1));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (sw_en_o == 12'd0));

    p_idle_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |=> !idle_o);

    p_load_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == GAP_LAST) |-> load_o);

    p_load_only_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (gap_q == GAP_LAST));

    p_err_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_o) |-> ($stable(err_o) && $stable(idle_o)));

endmodule

bind tmc_pwm_seq tmc_pwm_seq_chk #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_o  (load_o),
    .sw_en_o (sw_en_o),
    .idle_o  (idle_o),
    .err_o   (err_o)
);

// File: tb/sim_tmc_pwm_seq.sv
module sim_tmc_pwm_seq;

    localparam int CLK_HZ = 125_000_000;
    localparam int SW_HZ  = 625_000;
    localparam int FRAC_W = 8;
    localparam int P      = CLK_HZ / SW_HZ;   // 200 cycles
    localparam int W      = $clog2(P + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [2:0][4:0]     rvec_sel = '0;
    logic [2:0][W-1:0]   rvec_dur = '0;
    logic [2:0]          inv_sector = '0;
    logic [FRAC_W:0]     inv_da = '0;
    logic [FRAC_W:0]     inv_db = '0;
    logic                load_o;
    logic [11:0]         sw_en_o;
    logic                idle_o;
    logic                err_o;

    tmc_pwm_seq #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ), .FRAC_W(FRAC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rvec_sel(rvec_sel), .rvec_dur(rvec_dur),
        .inv_sector(inv_sector), .inv_da(inv_da), .inv_db(inv_db),
        .load_o(load_o), .sw_en_o(sw_en_o), .idle_o(idle_o), .err_o(err_o)
    );

    always #4 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    string tag   = "R2";

    // behavioural reference
    int          m_cnt;
    bit          m_loaded;
    bit          m_err;
    logic [11:0] m_pat [P];

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h at m_cnt=%0d", req, what, act, exp, m_cnt);
        end
    endtask

    function automatic void line_pair(input int k, output int p, output int n);
        case (k)
            1: begin p = 0; n = 1; end
            2: begin p = 0; n = 2; end
            3: begin p = 1; n = 2; end
            4: begin p = 1; n = 0; end
            5: begin p = 2; n = 0; end
            default: begin p = 2; n = 1; end
        endcase
    endfunction

    function automatic void phase_pair(input int k, output int p, output int n);
        case (k)
            1: begin p = 0; n = 3; end
            2: begin p = 3; n = 2; end
            3: begin p = 1; n = 3; end
            4: begin p = 3; n = 0; end
            5: begin p = 2; n = 3; end
            default: begin p = 3; n = 1; end
        endcase
    endfunction

    function automatic logic [2:0] inv_bits(input int k);
        case (k)
            1: return 3'b100;
            2: return 3'b110;
            3: return 3'b010;
            4: return 3'b011;
            5: return 3'b001;
            default: return 3'b101;
        endcase
    endfunction

    function automatic logic [11:0] gate(input int p, input int n, input logic [2:0] v);
        logic [11:0] r = '0;
        for (int t = 0; t < 3; t++) begin
            int s = v[2-t] ? p : n;
            r[t*4 + s] = 1'b1;
        end
        return r;
    endfunction

    function automatic bit frame_legal();
        int sum = 0;
        for (int s = 0; s < 3; s++) begin
            int kind = int'(rvec_sel[s][4:3]);
            int idx  = int'(rvec_sel[s][2:0]);
            int d    = int'(rvec_dur[s]);
            sum += d;
            if (kind == 0 && idx > 3) return 0;
            if (kind == 1 && (idx < 1 || idx > 6)) return 0;
            if (kind == 2 && (idx < 1 || idx > 6 || (d % 2) != 0)) return 0;
            if (kind == 3) return 0;
        end
        if (sum != P) return 0;
        if (inv_sector < 1 || inv_sector > 6) return 0;
        if (int'(inv_da) + int'(inv_db) != (1 << FRAC_W)) return 0;
        return 1;
    endfunction

    task automatic build_pattern();
        int pl[$]; int pp[$]; int pn[$];
        int pos = 0;
        int sec = int'(inv_sector);
        logic [2:0] va = inv_bits(sec);
        logic [2:0] vb = inv_bits(sec % 6 + 1);
        for (int s = 0; s < 3; s++) begin
            int kind = int'(rvec_sel[s][4:3]);
            int idx  = int'(rvec_sel[s][2:0]);
            int d    = int'(rvec_dur[s]);
            int p, n;
            if (kind == 0) begin
                pl.push_back(d); pp.push_back(idx); pn.push_back(idx);
            end else if (kind == 1) begin
                line_pair(idx, p, n);
                pl.push_back(d); pp.push_back(p); pn.push_back(n);
            end else begin
                phase_pair((idx == 1) ? 6 : idx - 1, p, n);
                pl.push_back(d / 2); pp.push_back(p); pn.push_back(n);
                phase_pair(idx, p, n);
                pl.push_back(d / 2); pp.push_back(p); pn.push_back(n);
            end
        end
        for (int i = 0; i < pl.size(); i++) begin
            int a = (pl[i] * int'(inv_da)) >> FRAC_W;
            for (int c = 0; c < pl[i]; c++) begin
                m_pat[pos] = gate(pp[i], pn[i], (c < a) ? va : vb);
                pos++;
            end
        end
    endtask

    task automatic model_advance();
        if (m_cnt == P - 1) begin
            m_cnt = 0;
            if (frame_legal()) begin
                build_pattern();
                m_loaded = 1;
                m_err    = 0;
            end else begin
                m_err = 1;
            end
        end else begin
            m_cnt++;
        end
    endtask

    task automatic compare();
        logic [11:0] exp_sw = m_loaded ? m_pat[m_cnt] : 12'd0;
        check(tag,  "sw_en", int'(sw_en_o), int'(exp_sw));
        check("R3", "load",  int'(load_o), (m_cnt == P - 1) ? 1 : 0);
        check("R2", "idle",  int'(idle_o), m_loaded ? 0 : 1);
        check("R4", "err",   int'(err_o),  int'(m_err));
        if (!idle_o) begin
            for (int t = 0; t < 3; t++) begin
                // R1: one source per terminal
                check("R1", "onehot", $countones(sw_en_o[t*4 +: 4]), 1);
            end
        end
    endtask

    task automatic tick();
        model_advance();
        @(negedge clk);
        compare();
    endtask

    task automatic run_periods(input int n);
        repeat (n * P) tick();
    endtask

    task automatic set_frame(input logic [4:0] s0, input int d0, input logic [4:0] s1, input int d1,
                             input logic [4:0] s2, input int d2, input int sec, input int da, input int db);
        rvec_sel[0] = s0; rvec_dur[0] = W'(d0);
        rvec_sel[1] = s1; rvec_dur[1] = W'(d1);
        rvec_sel[2] = s2; rvec_dur[2] = W'(d2);
        inv_sector  = 3'(sec);
        inv_da      = (FRAC_W+1)'(da);
        inv_db      = (FRAC_W+1)'(db);
    endtask

    initial begin
        #(8 * 100_000);
        n_err++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2", "reset sw",   int'(sw_en_o), 0);
        check("R2", "reset idle", int'(idle_o), 1);
        check("R2", "reset load", int'(load_o), 0);
        rst_n    = 1'b1;
        m_cnt    = 0;
        m_loaded = 0;
        m_err    = 0;
        compare();

        // R4: an all-zero frame is illegal, the block stays idle
        tag = "R2";
        run_periods(1);

        // R5: line AB, virtual 1, line AC; sector 1 with a 100/156 share
        tag = "R5";
        set_frame(5'b01_001, 80, 5'b10_001, 60, 5'b01_010, 60, 1, 100, 156);
        run_periods(2);

        // R7: two virtual vectors plus zero on N; sector 6 wraps to 1, full alpha
        tag = "R7";
        set_frame(5'b10_010, 70, 5'b10_001, 50, 5'b00_011, 80, 6, 256, 0);
        run_periods(2);

        // R8: zero on A, line CB, virtual 6; all-beta share
        tag = "R8";
        set_frame(5'b00_000, 40, 5'b01_110, 100, 5'b10_110, 60, 3, 0, 256);
        run_periods(2);

        // R6: lines BC, BA, CA; sector 4 with an even split
        tag = "R6";
        set_frame(5'b01_011, 70, 5'b01_100, 60, 5'b01_101, 70, 4, 128, 128);
        run_periods(2);

        // R4: durations sum to 199, the previous frame is replayed
        tag = "R4";
        set_frame(5'b01_001, 70, 5'b01_010, 60, 5'b01_011, 69, 2, 128, 128);
        run_periods(2);
        // R4: odd duration on a virtual vector
        set_frame(5'b10_011, 61, 5'b01_010, 69, 5'b01_011, 70, 2, 128, 128);
        run_periods(1);
        // R4: sector out of range
        set_frame(5'b01_001, 70, 5'b01_010, 60, 5'b01_011, 70, 7, 128, 128);
        run_periods(1);
        // R4: shares do not sum to full scale, plus a reserved zero index
        set_frame(5'b00_100, 70, 5'b01_010, 60, 5'b01_011, 70, 2, 128, 127);
        run_periods(1);
        // R4: reserved selector kind
        set_frame(5'b11_001, 70, 5'b01_010, 60, 5'b01_011, 70, 2, 128, 128);
        run_periods(1);

        // R9: sector 2 with an uneven share; a zero-length first slot
        tag = "R9";
        set_frame(5'b01_001, 0, 5'b01_110, 150, 5'b00_010, 50, 2, 37, 219);
        run_periods(2);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule